// File: doc/BRIEF.md
# PCI Host Configuration Access Front End

This block sits between a 32-bit little-endian register request stream and the configuration-cycle engine of a PCI host bridge. Software first writes the target of a configuration access into a configuration address word at offset 0x0. It then reads or writes the data window at offset 0x4. Each data-window access becomes one request to the external configuration-cycle interface. That request carries the latched address word, the byte enables, a direction flag and the write data, and the block waits until the external side accepts it.

Software that forgets the enable bit, or leaves the two low bits non-zero, still works. Each full-word write to the address word is stored with bit 31 forced high and bits 1:0 forced low. Partial writes to that word are dropped. A window of internal registers starts at offset 0x80000 and spans 0xFF bytes. In that window only the status word at 0xE0 is implemented. Every other offset, inside or outside the window, reads as zero and ignores writes.

Requests use a valid/ready stream, and so do responses. The block keeps exactly one access outstanding. `req_ready` stays low from the cycle a request is accepted until its response has been taken. A response stays on `rsp_valid`/`rsp_rdata`, unchanged, for as long as `rsp_ready` is held low. A configuration request stays on `cfg_valid` and its fields, unchanged, until `cfg_ready` is seen.

Top module: `pcf_front`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` and `cfg_valid` are 0, and both the address word and the status word read as zero.
- R2: A write to offset 0x0 with `req_be` = 4'hF stores `{1'b1, wdata[30:2], 2'b00}`.
- R3: A write to offset 0x0 with any `req_be` other than 4'hF leaves the stored address word unchanged.
- R4: A read of offset 0x0 returns the stored address word exactly as stored.
- R5: An access to offset 0x4 raises `cfg_valid` in the cycle after acceptance. It presents `cfg_addr` equal to the stored address word, together with the request's `cfg_be`, `cfg_write` and `cfg_wdata`. All of these are held stable until `cfg_ready` is 1.
- R6: A data-window read completes with `rsp_rdata` equal to `cfg_rdata` as sampled in the `cfg_ready` cycle. A data-window write completes with `rsp_rdata` = 0.
- R7: The status word at offset 0x800E0 resets to zero. A write updates only the byte lanes whose `req_be` bit is set, where lane i is bits 8i+7:8i (little-endian). A read returns the stored word.
- R8: A read of any other offset returns 0, whether inside the internal window (for example 0x800FC) or outside it (for example 0x8 or 0x80100). A write there changes neither the address word nor the status word.
- R9: Only one access is outstanding at a time. Exactly one of `req_ready`, `cfg_valid` and `rsp_valid` is high in every cycle. A response held with `rsp_ready` low keeps `rsp_valid` high and `rsp_rdata` stable.
- R10: For a register access (any offset except 0x4), `rsp_valid` is high in the cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Register request valid |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset of the word |
| req_be | input | 4 | Byte enables, lane 0 = bits 7:0 |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response taken |
| rsp_rdata | output | 32 | Read data (0 for writes) |
| cfg_valid | output | 1 | Configuration request pending |
| cfg_ready | input | 1 | External side accepts request and returns data |
| cfg_write | output | 1 | Direction of the configuration request |
| cfg_addr | output | 32 | Latched configuration address word |
| cfg_be | output | 4 | Byte enables of the configuration request |
| cfg_wdata | output | 32 | Write data of the configuration request |
| cfg_rdata | input | 32 | Read data, valid with cfg_ready |

## Verification
The bench builds the block with its default parameters: a 20-bit offset, the internal window at 0x80000 with a span of 0xFF, and the status word at 0xE0. With these values the bench can reach undefined offsets on both sides of the window edge (0x800FC inside, 0x80100 outside) and low offsets next to the two configuration words. Random byte-enable patterns against the status word exercise every lane combination. Random hold-off on `cfg_ready` and `rsp_ready` covers the stall paths of both handshakes.

// File: rtl/pcf_pkg.sv
package pcf_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CFG  = 2'd1,
    ST_RESP = 2'd2
  } pcf_state_e;

  typedef enum logic [1:0] {
    SEL_ADDR = 2'd0,
    SEL_DATA = 2'd1,
    SEL_STS  = 2'd2,
    SEL_NONE = 2'd3
  } pcf_sel_e;

  localparam int unsigned WORD_W  = 32;
  localparam int unsigned LANES   = WORD_W / 8;
  localparam int unsigned EN_BIT  = 31;

  function automatic logic [WORD_W-1:0] pcf_fixup(input logic [WORD_W-1:0] d);
    logic [WORD_W-1:0] r;
    r         = d;
    r[1:0]    = 2'b00;
    r[EN_BIT] = 1'b1;
    return r;
  endfunction

endpackage

// File: rtl/pcf_decode.sv
module pcf_decode
  import pcf_pkg::*;
#(
  parameter int unsigned ADDR_W   = 20,
  parameter int unsigned REG_BASE = 32'h80000,
  parameter int unsigned REG_SPAN = 32'hFF,
  parameter int unsigned STS_OFF  = 32'hE0
) (
  input  logic [ADDR_W-1:0] addr,
  output pcf_sel_e          sel
);
  localparam int unsigned CFG_ADDR_OFF = 0;
  localparam int unsigned CFG_DATA_OFF = 4;
  localparam int unsigned WIN_END      = REG_BASE + REG_SPAN;
  localparam int unsigned STS_ABS      = REG_BASE + STS_OFF;

  logic [31:0] a32;
  logic        in_win;

  always_comb begin
    a32    = 32'(addr);
    in_win = (a32 >= REG_BASE) && (a32 < WIN_END);
    if (a32 == CFG_ADDR_OFF)               sel = SEL_ADDR;
    else if (a32 == CFG_DATA_OFF)          sel = SEL_DATA;
    else if (in_win && (a32 == STS_ABS))   sel = SEL_STS;
    else                                   sel = SEL_NONE;
  end
endmodule

// File: rtl/pcf_addr_reg.sv
module pcf_addr_reg
  import pcf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [LANES-1:0]  wr_be,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] addr_q
);
  logic full_word;
  assign full_word = &wr_be;

  always_ff @(posedge clk) begin
    if (!rst_n)                  addr_q <= '0;
    else if (wr_en && full_word) addr_q <= pcf_fixup(wdata);
  end

  // R2: accepted write lands with enable set and low bits clear
  a_r2_fixup: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_be == '1)) |=>
      (addr_q[EN_BIT] && (addr_q[1:0] == 2'b00) &&
       (addr_q[EN_BIT-1:2] == $past(wdata[EN_BIT-1:2]))));

  // R3: a partial write leaves the word alone
  a_r3_partial_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_be != '1)) |=> $stable(addr_q));

  // R2: once written, the stored word never has low bits set
  a_r2_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_q != '0) |-> (addr_q[EN_BIT] && (addr_q[1:0] == 2'b00)));
endmodule

// File: rtl/pcf_sts_reg.sv
module pcf_sts_reg
  import pcf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [LANES-1:0]  wr_be,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] sts_q
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rst_n)                sts_q[8*i +: 8] <= 8'h00;
      else if (wr_en && wr_be[i]) sts_q[8*i +: 8] <= wdata[8*i +: 8];
    end

    // R7: a lane whose enable is low keeps its byte
    a_r7_lane_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_be[i]) |=> $stable(sts_q[8*i +: 8]));

    // R7: a lane whose enable is high takes the written byte
    a_r7_lane_take: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_be[i]) |=> (sts_q[8*i +: 8] == $past(wdata[8*i +: 8])));
  end
endmodule

// File: rtl/pcf_front.sv
module pcf_front
  import pcf_pkg::*;
#(
  parameter int unsigned ADDR_W   = 20,
  parameter int unsigned REG_BASE = 32'h80000,
  parameter int unsigned REG_SPAN = 32'hFF,
  parameter int unsigned STS_OFF  = 32'hE0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [3:0]        req_be,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [31:0]       rsp_rdata,
  output logic              cfg_valid,
  input  logic              cfg_ready,
  output logic              cfg_write,
  output logic [31:0]       cfg_addr,
  output logic [3:0]        cfg_be,
  output logic [31:0]       cfg_wdata,
  input  logic [31:0]       cfg_rdata
);
  pcf_state_e        state_q;
  pcf_sel_e          sel;
  logic              accept;
  logic [WORD_W-1:0] addr_q, sts_q, rd_val, rdata_q;
  logic              cfg_write_q;
  logic [LANES-1:0]  cfg_be_q;
  logic [WORD_W-1:0] cfg_wdata_q;

  pcf_decode #(
    .ADDR_W(ADDR_W), .REG_BASE(REG_BASE), .REG_SPAN(REG_SPAN), .STS_OFF(STS_OFF)
  ) u_dec (
    .addr (req_addr),
    .sel  (sel)
  );

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;

  pcf_addr_reg u_addr (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (accept && req_write && (sel == SEL_ADDR)),
    .wr_be  (req_be),
    .wdata  (req_wdata),
    .addr_q (addr_q)
  );

  pcf_sts_reg u_sts (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (accept && req_write && (sel == SEL_STS)),
    .wr_be (req_be),
    .wdata (req_wdata),
    .sts_q (sts_q)
  );

  always_comb begin
    unique case (sel)
      SEL_ADDR: rd_val = addr_q;
      SEL_STS:  rd_val = sts_q;
      default:  rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      rdata_q     <= '0;
      cfg_write_q <= 1'b0;
      cfg_be_q    <= '0;
      cfg_wdata_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) begin
          if (sel == SEL_DATA) begin
            state_q     <= ST_CFG;
            cfg_write_q <= req_write;
            cfg_be_q    <= req_be;
            cfg_wdata_q <= req_wdata;
          end else begin
            state_q <= ST_RESP;
            rdata_q <= req_write ? '0 : rd_val;
          end
        end
        ST_CFG: if (cfg_ready) begin
          state_q <= ST_RESP;
          rdata_q <= cfg_write_q ? '0 : cfg_rdata;
        end
        ST_RESP: if (rsp_ready) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rsp_valid = (state_q == ST_RESP);
  assign rsp_rdata = rdata_q;
  assign cfg_valid = (state_q == ST_CFG);
  assign cfg_write = cfg_write_q;
  assign cfg_addr  = addr_q;
  assign cfg_be    = cfg_be_q;
  assign cfg_wdata = cfg_wdata_q;

  // R9: exactly one phase visible at a time
  a_r9_one_phase: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({req_ready, cfg_valid, rsp_valid}) == 1);

  // R9: a stalled response keeps its data
  a_r9_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));

  // R5: a stalled config request keeps all its fields
  a_r5_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && !cfg_ready) |=>
      (cfg_valid && $stable(cfg_addr) && $stable(cfg_be) &&
       $stable(cfg_write) && $stable(cfg_wdata)));

  // R5: a data-window access starts a config request next cycle
  a_r5_cfg_start: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (sel == SEL_DATA)) |=> (cfg_valid && (cfg_be == $past(req_be))));

  // R10: register accesses answer one cycle after acceptance
  a_r10_reg_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (sel != SEL_DATA)) |=> rsp_valid);

  // R6: a config read hands back the external data
  a_r6_cfg_data: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && cfg_ready && !cfg_write) |=> (rsp_rdata == $past(cfg_rdata)));
endmodule

// File: tb/pcf_front_tb_top.sv
module pcf_front_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [19:0] req_addr = '0;
  logic [3:0]  req_be = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_ready = 1'b0, cfg_ready = 1'b0;
  logic [31:0] cfg_rdata = '0;
  logic        req_ready, rsp_valid, cfg_valid, cfg_write;
  logic [31:0] rsp_rdata, cfg_addr, cfg_wdata;
  logic [3:0]  cfg_be;

  int n_tests = 0;
  int n_fail  = 0;
  logic [31:0] m_addr = '0;
  logic [31:0] m_sts  = '0;

  always #4 clk = ~clk;

  pcf_front dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .cfg_valid(cfg_valid), .cfg_ready(cfg_ready), .cfg_write(cfg_write),
    .cfg_addr(cfg_addr), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata)
  );

  function automatic logic [31:0] exp_fix(input logic [31:0] d);
    return {1'b1, d[30:2], 2'b00};
  endfunction

  function automatic logic [31:0] exp_merge(input logic [31:0] old,
                                            input logic [31:0] d,
                                            input logic [3:0] be);
    logic [31:0] r = old;
    for (int i = 0; i < 4; i++) if (be[i]) r[8*i +: 8] = d[8*i +: 8];
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  // One access through the request stream; bp = stall cycles on both handshakes
  task automatic access(input logic w, input logic [19:0] a, input logic [3:0] be,
                        input logic [31:0] d, input int bp, input string req,
                        input logic [31:0] exp);
    logic [31:0] ext, held;
    bit is_cfg = (a == 20'h4);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_be = be; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (is_cfg) begin
      check("R5 cfg_valid", {31'b0, cfg_valid}, 32'd1);
      check("R5 cfg_addr", cfg_addr, m_addr);
      check("R5 cfg_be", {28'b0, cfg_be}, {28'b0, be});
      check("R5 cfg_write", {31'b0, cfg_write}, {31'b0, w});
      if (w) check("R5 cfg_wdata", cfg_wdata, d);
      check("R9 busy", {31'b0, req_ready}, 32'd0);
      for (int k = 0; k < bp; k++) begin
        @(negedge clk);
        check("R5 cfg held", {31'b0, cfg_valid}, 32'd1);
        check("R5 cfg_addr held", cfg_addr, m_addr);
      end
      ext = $urandom;
      cfg_ready = 1'b1; cfg_rdata = ext;
      @(negedge clk);
      cfg_ready = 1'b0; cfg_rdata = $urandom;
      check("R6 rsp_valid", {31'b0, rsp_valid}, 32'd1);
      check("R6 rsp_rdata", rsp_rdata, w ? 32'h0 : ext);
    end else begin
      check("R10 rsp_valid next cycle", {31'b0, rsp_valid}, 32'd1);
      check(req, rsp_rdata, exp);
    end
    held = rsp_rdata;
    for (int k = 0; k < bp; k++) begin
      @(negedge clk);
      check("R9 rsp held", {31'b0, rsp_valid}, 32'd1);
      check("R9 rsp stable", rsp_rdata, held);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    check("R9 idle after response", {31'b0, req_ready}, 32'd1);
  endtask

  task automatic rd_addr(input int bp);  access(1'b0, 20'h0, 4'hF, 0, bp, "R4 addr read", m_addr); endtask
  task automatic rd_sts(input int bp);   access(1'b0, 20'h800E0, 4'hF, 0, bp, "R7 status read", m_sts); endtask

  task automatic wr_addr(input logic [3:0] be, input logic [31:0] d);
    access(1'b1, 20'h0, be, d, 0, "R2 addr write rsp", 32'h0);
    if (be == 4'hF) m_addr = exp_fix(d);
  endtask

  task automatic wr_sts(input logic [3:0] be, input logic [31:0] d);
    access(1'b1, 20'h800E0, be, d, 0, "R7 status write rsp", 32'h0);
    m_sts = exp_merge(m_sts, d, be);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    logic [19:0] undef_list [6];
    void'($urandom(32'd20240611));
    undef_list = '{20'h00008, 20'h800FC, 20'h80100, 20'h800E4, 20'h80000, 20'h7FFFC};
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 req_ready", {31'b0, req_ready}, 32'd1);
    check("R1 rsp_valid", {31'b0, rsp_valid}, 32'd0);
    check("R1 cfg_valid", {31'b0, cfg_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 req_ready after reset", {31'b0, req_ready}, 32'd1);
    access(1'b0, 20'h0, 4'hF, 0, 0, "R1 addr reset", 32'h0);
    access(1'b0, 20'h800E0, 4'hF, 0, 0, "R1 status reset", 32'h0);

    // Directed: fix-up corners
    wr_addr(4'hF, 32'h0000_0003); rd_addr(0);
    check("R2 enable forced", m_addr, 32'h8000_0000);
    wr_addr(4'hF, 32'hFFFF_FFFF); rd_addr(1);
    wr_addr(4'h7, 32'h1234_5678); rd_addr(0);   // R3: partial ignored
    wr_addr(4'h0, 32'h0000_0000); rd_addr(0);   // R3: no lanes ignored
    wr_addr(4'hF, 32'h0001_0802); rd_addr(2);

    // Directed: data window
    access(1'b0, 20'h4, 4'hF, 0, 0, "R6", 0);
    access(1'b1, 20'h4, 4'h3, 32'hCAFE_F00D, 3, "R6", 0);

    // Directed: status lanes and undefined offsets
    wr_sts(4'h5, 32'hA1B2_C3D4); rd_sts(0);
    wr_sts(4'hA, 32'h1122_3344); rd_sts(2);
    foreach (undef_list[i]) begin
      access(1'b1, undef_list[i], 4'hF, 32'hDEAD_BEEF, 0, "R8 undef write rsp", 32'h0);
      access(1'b0, undef_list[i], 4'hF, 0, 0, "R8 undef read zero", 32'h0);
    end
    rd_sts(0); rd_addr(0);   // R8: unchanged by undefined writes

    // Random mix
    for (int it = 0; it < 400; it++) begin
      int op = $urandom_range(0, 7);
      int bp = ($urandom_range(0, 3) == 0) ? $urandom_range(1, 4) : 0;
      logic [31:0] d = $urandom;
      logic [3:0] be = ($urandom_range(0, 1) == 1) ? 4'hF : 4'($urandom);
      case (op)
        0: wr_addr(be, d);
        1: rd_addr(bp);
        2: wr_sts(be, d);
        3: rd_sts(bp);
        4: access(1'b1, undef_list[$urandom_range(0, 5)], be, d, bp, "R8 undef write rsp", 32'h0);
        5: access(1'b0, undef_list[$urandom_range(0, 5)], be, d, bp, "R8 undef read zero", 32'h0);
        6: access(1'b0, 20'h4, be, 0, bp, "R6", 0);
        default: access(1'b1, 20'h4, be, d, bp, "R6", 0);
      endcase
    end
    rd_addr(0); rd_sts(0);
    finish_run();
  end
endmodule